// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block connects a clocked internal requester to an external asynchronous static RAM of 8192 bytes. The requester presents an address, a read/write flag and, for writes, a data byte, together with a request strobe. The controller accepts the request only while `ready_o` is high. It then runs the external control pins through a fixed sequence of phases. Every phase length is a whole number of clock cycles, derived from a timing parameter in picoseconds and the clock period.

On the memory side the controller drives a 13-bit address, two chip enables of opposite polarity, an active-low write strobe and an active-low output enable. It also has a shared 8-bit data path, presented as an output value, an output-drive enable and an input value for the pad ring. Writes drive the bus from the setup phase until after the write strobe has risen. The data therefore stays stable through the terminating edge. Reads leave the bus released, keep output enable low for the access window, capture the byte at the end of that window, and then wait a turnaround period before the controller becomes idle again.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no request, the outputs are `mem_cs_no`=1, `mem_cs_o`=0, `mem_we_no`=1, `mem_oe_no`=1, `mem_dq_oe_o`=0 and `ready_o`=1. A reset asserted in the middle of a cycle forces these levels at once.
- R2: An accepted write (`write_i`=1) holds `mem_addr_o` at the request address, with `mem_cs_no`=0 and `mem_cs_o`=1, for the whole sequence. The sequence is one setup cycle with `mem_we_no` high, then `mem_we_no` low for 3 cycles, then one hold cycle with `mem_we_no` high. With the default parameters, `ready_o` returns 5 clock edges after the accepting edge.
- R3: Throughout a write, `mem_dq_oe_o`=1, `mem_dq_o` equals the accepted write byte and `mem_oe_no`=1. The write strobe and output enable are never low at the same time.
- R4: An accepted read (`write_i`=0) holds `mem_oe_no` low for 4 cycles, with `mem_we_no` high and `mem_dq_oe_o`=0. The byte on `mem_dq_i` at the end of that window appears on `rdata_o`, with a one-cycle `rvalid_o` pulse 4 edges after acceptance.
- R5: After a read access, `mem_oe_no` is high and the bus stays released for 2 turnaround cycles before `ready_o` rises. With the default parameters this is 6 edges after acceptance.
- R6: A request presented while `ready_o` is low is ignored. It starts no cycle and changes no memory location.
- R7: Each phase length is the ceiling of its time divided by `CLK_PS`, with a minimum of one cycle. The write strobe length is the larger of the pulse-width and data-setup counts. The read window is the largest of the cycle-time, address-access and output-enable-access counts.
- R8: Every one of the 8192 addresses can be written and then read back with the same byte.
- R9: While `ready_o` is high, both chip enables are inactive (`mem_cs_no`=1, `mem_cs_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled while ready_o is high |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Request address |
| wdata_i | input | 8 | Write byte |
| ready_o | output | 1 | Controller idle, request may be presented |
| rvalid_o | output | 1 | One-cycle strobe, rdata_o holds read byte |
| rdata_o | output | 8 | Captured read byte |
| mem_addr_o | output | 13 | Memory address |
| mem_cs_no | output | 1 | Active-low chip enable |
| mem_cs_o | output | 1 | Active-high chip enable |
| mem_we_no | output | 1 | Active-low write strobe |
| mem_oe_no | output | 1 | Active-low output enable |
| mem_dq_o | output | 8 | Data driven onto the bus |
| mem_dq_oe_o | output | 1 | Bus drive enable |
| mem_dq_i | input | 8 | Data received from the bus |

## Verification
Counted from the clock edge that accepts a request, the write strobe falls after 1 edge and rises after 4, and `ready_o` returns after 5. For a read, `rvalid_o` with its byte is due after 4 edges and `ready_o` after 6. The bench recomputes these counts from the timing parameters with its own ceiling arithmetic. It samples every output at the falling clock edge following each rising edge and indexes each observation by the number of rising edges since acceptance, so every comparison falls in the cycle the count predicts. A memory model in the bench commits data only on the rising edge of the write strobe, so a byte that is unstable through the terminating edge shows up on read-back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACCESS,
    ST_RTURN
  } state_e;

  // ceiling of t/clk, never below one cycle
  function automatic int unsigned ps2cyc(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CW = 3,
  parameter int unsigned NS = 1,
  parameter int unsigned NP = 3,
  parameter int unsigned NH = 1,
  parameter int unsigned NA = 4,
  parameter int unsigned NT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          write_i,
  input  logic          last_i,
  output state_e        state_q_o,
  output state_e        state_d_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          accept_o,
  output logic          rd_done_o
);
  localparam logic [CW-1:0] LS = CW'(NS - 1);
  localparam logic [CW-1:0] LP = CW'(NP - 1);
  localparam logic [CW-1:0] LH = CW'(NH - 1);
  localparam logic [CW-1:0] LA = CW'(NA - 1);
  localparam logic [CW-1:0] LT = CW'(NT - 1);

  state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    rd_done_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o   = 1'b1;
        load_o     = 1'b1;
        state_d    = write_i ? ST_WSETUP : ST_RACCESS;
        load_val_o = write_i ? LS : LA;
      end
      ST_WSETUP: if (last_i) begin
        state_d = ST_WPULSE; load_o = 1'b1; load_val_o = LP;
      end
      ST_WPULSE: if (last_i) begin
        state_d = ST_WHOLD; load_o = 1'b1; load_val_o = LH;
      end
      ST_WHOLD: if (last_i) state_d = ST_IDLE;
      ST_RACCESS: if (last_i) begin
        state_d = ST_RTURN; load_o = 1'b1; load_val_o = LT; rd_done_o = 1'b1;
      end
      ST_RTURN: if (last_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_PS    = 5000,
  parameter int unsigned T_SA_PS   = 0,
  parameter int unsigned T_PWE_PS  = 15000,
  parameter int unsigned T_SD_PS   = 10000,
  parameter int unsigned T_HA_PS   = 0,
  parameter int unsigned T_RC_PS   = 20000,
  parameter int unsigned T_AA_PS   = 20000,
  parameter int unsigned T_DOE_PS  = 10000,
  parameter int unsigned T_HZOE_PS = 8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_no,
  output logic              mem_cs_o,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned NS   = ps2cyc(T_SA_PS, CLK_PS);
  localparam int unsigned NP   = umax(ps2cyc(T_PWE_PS, CLK_PS), ps2cyc(T_SD_PS, CLK_PS));
  localparam int unsigned NH   = ps2cyc(T_HA_PS, CLK_PS);
  localparam int unsigned NA   = umax(ps2cyc(T_RC_PS, CLK_PS),
                                      umax(ps2cyc(T_AA_PS, CLK_PS), ps2cyc(T_DOE_PS, CLK_PS)));
  localparam int unsigned NT   = ps2cyc(T_HZOE_PS, CLK_PS);
  localparam int unsigned NMAX = umax(umax(NS, NP), umax(umax(NH, NA), NT));
  localparam int unsigned CW   = $clog2(NMAX + 1);

  state_e        state_q, state_d;
  logic          load, last, accept, rd_done;
  logic [CW-1:0] load_val;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  sram_seq_fsm #(
    .CW(CW), .NS(NS), .NP(NP), .NH(NH), .NA(NA), .NT(NT)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .write_i    (write_i),
    .last_i     (last),
    .state_q_o  (state_q),
    .state_d_o  (state_d),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .rd_done_o  (rd_done)
  );

  // request capture
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  // pin flops, decoded from next state so pins change glitch-free with state
  logic cs_n_q, cs_q, we_n_q, oe_n_q, dq_oe_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_q  <= 1'b1;
      cs_q    <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      cs_n_q  <= (state_d == ST_IDLE);
      cs_q    <= (state_d != ST_IDLE);
      we_n_q  <= (state_d != ST_WPULSE);
      oe_n_q  <= (state_d != ST_RACCESS);
      dq_oe_q <= (state_d == ST_WSETUP) || (state_d == ST_WPULSE) || (state_d == ST_WHOLD);
    end
  end

  // read capture at the end of the access window
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_done;
      if (rd_done) rdata_q <= mem_dq_i;
    end
  end

  assign ready_o     = (state_q == ST_IDLE);
  assign rvalid_o    = rvalid_q;
  assign rdata_o     = rdata_q;
  assign mem_addr_o  = addr_q;
  assign mem_cs_no   = cs_n_q;
  assign mem_cs_o    = cs_q;
  assign mem_we_no   = we_n_q;
  assign mem_oe_no   = oe_n_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = dq_oe_q;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs_no,
  input logic              mem_cs_o,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);
  AST_WE_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_we_no && !mem_oe_no)); // R3
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no); // R3
  AST_WE_NEEDS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_cs_no && mem_cs_o && mem_dq_oe_o)); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !$past(ready_o)) |-> $stable(mem_addr_o)); // R2
  AST_WDATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o)); // R3
  AST_RVALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R4
  AST_RVALID_AFTER_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rvalid_o) |-> ($fell(mem_oe_no) == 1'b0 && mem_oe_no && !mem_dq_oe_o)); // R5
  AST_IDLE_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_cs_no && !mem_cs_o)); // R9
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .mem_addr_o  (mem_addr_o),
  .mem_cs_no   (mem_cs_no),
  .mem_cs_o    (mem_cs_o),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_dq_o    (mem_dq_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;
  localparam int CLK_PS = 5000;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  function automatic int cyc(input int t);
    int c;
    c = (t + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R7: expected phase counts from the default timing values
  localparam int E_NS = cyc(0);
  localparam int E_NP = mx(cyc(15000), cyc(10000));
  localparam int E_NH = cyc(0);
  localparam int E_NA = mx(cyc(20000), mx(cyc(20000), cyc(10000)));
  localparam int E_NT = cyc(8000);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready, rvalid;
  logic [DW-1:0] rdata;
  logic [AW-1:0] m_addr;
  logic cs_n, cs, we_n, oe_n, dq_oe;
  logic [DW-1:0] dq_o, dq_i;

  always #2500 clk = ~clk;

  sram_async_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .write_i(wr), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata),
    .mem_addr_o(m_addr), .mem_cs_no(cs_n), .mem_cs_o(cs), .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  // memory model: commits on the terminating rising edge of the write strobe
  logic [DW-1:0] mem [DEPTH];
  assign dq_i = (!cs_n && cs && !oe_n && we_n) ? mem[m_addr] : 8'h00;
  always @(posedge we_n) if (!cs_n && cs && dq_oe) mem[m_addr] = dq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int seed);
    return DW'((a * 7) + ((a >> 8) * 13) + seed);
  endfunction

  // inject: present a second request (addr b) while busy
  task automatic do_write(input int a, input logic [DW-1:0] d, input bit inject, input int b);
    int we_first, we_cnt, rdy_k, bad_drive, bad_oe, bad_sel;
    we_first = 0; we_cnt = 0; rdy_k = 0; bad_drive = 0; bad_oe = 0; bad_sel = 0;
    @(negedge clk); req = 1'b1; wr = 1'b1; addr = AW'(a); wdata = d;
    @(posedge clk);
    @(negedge clk);
    if (inject) begin addr = AW'(b); wdata = ~d; end else req = 1'b0;
    for (int k = 1; k <= 16; k++) begin
      if (k > 1) @(negedge clk);
      if (ready) begin rdy_k = k; break; end
      if (!we_n) begin if (we_first == 0) we_first = k; we_cnt++; end
      if (!dq_oe || dq_o != d) bad_drive++;
      if (!oe_n) bad_oe++;
      if (cs_n || !cs || m_addr != AW'(a)) bad_sel++;
    end
    req = 1'b0;
    check(we_first == E_NS + 1, "R2 we fall", we_first, E_NS + 1);
    check(we_cnt == E_NP, "R2 we width", we_cnt, E_NP);
    check(rdy_k == E_NS + E_NP + E_NH + 1, "R2 ready", rdy_k, E_NS + E_NP + E_NH + 1);
    check(bad_sel == 0, "R2 select/addr", bad_sel, 0);
    check(bad_drive == 0 && bad_oe == 0, "R3 drive", bad_drive + bad_oe, 0);
    check(cs_n && !cs, "R9 idle deselect", cs_n, 1);
  endtask

  task automatic do_read(input int a, input logic [DW-1:0] exp_d);
    int oe_cnt, rv_k, rdy_k, turn, bad_drive;
    logic [DW-1:0] got;
    oe_cnt = 0; rv_k = 0; rdy_k = 0; turn = 0; bad_drive = 0; got = '0;
    @(negedge clk); req = 1'b1; wr = 1'b0; addr = AW'(a);
    @(posedge clk);
    @(negedge clk); req = 1'b0;
    for (int k = 1; k <= 16; k++) begin
      if (k > 1) @(negedge clk);
      if (rvalid) begin if (rv_k == 0) rv_k = k; got = rdata; end
      if (ready) begin rdy_k = k; break; end
      if (!oe_n) oe_cnt++; else turn++;
      if (dq_oe || !we_n) bad_drive++;
    end
    check(oe_cnt == E_NA, "R4 oe width", oe_cnt, E_NA);
    check(rv_k == E_NA + 1, "R4 rvalid time", rv_k, E_NA + 1);
    check(got == exp_d, "R8 read data", int'(got), int'(exp_d));
    check(turn == E_NT && rdy_k == E_NA + E_NT + 1, "R5 turnaround", rdy_k, E_NA + E_NT + 1);
    check(bad_drive == 0, "R4 bus released", bad_drive, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset levels
    check(cs_n && !cs && we_n && oe_n && !dq_oe && ready, "R1 reset", {cs_n, cs, we_n, oe_n, dq_oe, ready}, 6'b101101);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n && !cs && we_n && oe_n && !dq_oe && ready && !rvalid, "R1 idle", {cs_n, cs, we_n, oe_n, dq_oe, ready}, 6'b101101);
    // R7: default counts are as derived
    check(E_NS == 1 && E_NP == 3 && E_NH == 1 && E_NA == 4 && E_NT == 2, "R7 counts", E_NP * 10 + E_NA, 34);
    // R8: full sweep
    for (int a = 0; a < DEPTH; a++) do_write(a, pat(a, 0), 1'b0, 0);
    for (int a = 0; a < DEPTH; a++) do_read(a, pat(a, 0));
    // R6: request held during a busy write must be ignored
    do_write(100, 8'h3C, 1'b1, 200);
    repeat (3) @(negedge clk);
    check(ready && cs_n, "R6 no new cycle", ready, 1);
    do_read(200, pat(200, 0));
    do_read(100, 8'h3C);
    // back-to-back write after read, write boundary addresses
    do_write(DEPTH - 1, 8'hFF, 1'b0, 0);
    do_write(0, 8'h00, 1'b0, 0);
    do_read(DEPTH - 1, 8'hFF);
    do_read(0, 8'h00);
    // R1: reset in the middle of a write strobe
    @(negedge clk); req = 1'b1; wr = 1'b1; addr = 13'd55; wdata = 8'h99;
    @(posedge clk); @(negedge clk); req = 1'b0;
    @(negedge clk); @(negedge clk);
    check(!we_n, "R2 strobe active before reset", we_n, 0);
    #100 rst_n = 1'b0;
    #100;
    check(cs_n && !cs && we_n && oe_n && !dq_oe && ready, "R1 mid-cycle reset", {cs_n, cs, we_n, oe_n, dq_oe, ready}, 6'b101101);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ready && cs_n && !cs, "R9 after reset", ready, 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule